// File: doc/BRIEF.md
# SPI Serial RAM Target

This block is the target side of a four-wire serial link, clock-idle-low, sampling on the rising clock edge and shifting on the falling one. Behind the link sits a byte-addressed RAM, held in an internal register file. The host opens a frame by pulling the select line low and sends a one-byte command. A read or write command is followed by a two-byte address, high byte first, and then any number of data bytes. The address pointer advances after every data byte, so bursts work. A status byte holds a write-enable latch, two protect bits, a mode flag, a page-wrap flag and an auto-store flag. Stores into the array or into the status byte are refused unless the latch has been armed. The latch disarms itself once a store frame has committed data.

All serial inputs are sampled with the system clock through a synchronizer chain. A byte-level controller then works from edge-detected strobes. The controller has eight named states. OPCODE takes the command byte. It moves to ADDR_HI on a read, or on an armed write. It moves to SR_WRITE on an armed status store and to SR_READ on a status fetch. Every other command goes to IGNORE. ADDR_HI always moves on to ADDR_LO. ADDR_LO moves to WR_DATA or RD_DATA, depending on the command that opened the frame. SR_WRITE moves to IGNORE after its one data byte. WR_DATA, RD_DATA, SR_READ and IGNORE each stay in place until the frame ends. A rising select line returns any state to OPCODE. The array depth is a parameter: a full 8 KiB part uses `ADDR_W` = 13. The default builds a smaller array of 2 KiB, and address bits above `ADDR_W` are don't-care.

Top module: `sram_spi_target`

## Requirements
- R1: Command 0x06 arms the write-enable latch and command 0x04 disarms it. The latch is visible as status bit 1.
- R2: Command 0x05 returns the status byte MSB first. Its layout is: bit 0 busy (always 0), bit 1 latch, bits 2 and 3 protect, bit 4 mode flag, bit 5 page wrap, bit 6 auto-store, bit 7 always 0. The byte repeats for as long as the frame is held open.
- R3: Command 0x01 followed by one data byte, with the latch armed, stores data bits 6..2 into status bits 6..2. Data bits 7, 1 and 0 have no effect.
- R4: Command 0x02, a high address byte, a low address byte, then N data bytes, with the latch armed, stores the data at consecutive pointer positions.
- R5: Command 0x03, then the two address bytes, returns array bytes from that address onward, one per byte slot, with the pointer advancing after each slot.
- R6: A 0x02 or 0x01 frame received while the latch is disarmed changes neither the array nor the status byte.
- R7: The latch disarms when select rises, if at least one data byte of an armed array or status store was completed. A store frame that ends before any full data byte leaves the latch armed.
- R8: With status bit 5 set, the pointer wraps from the last byte of a 32-byte page to the first byte of the same page, for both reads and writes.
- R9: With status bit 5 clear, the pointer increments linearly and wraps from the last array byte to 0. Address bits at or above `ADDR_W` are ignored.
- R10: A data byte cut short by select rising is discarded: nothing is written and the latch stays armed.
- R11: Unknown command codes change nothing. MISO is 0 while select is high, and any state returns to OPCODE when select rises.
- R12: After reset the status byte reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the link |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the host, idle low |
| spi_csn | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Host-to-target data, MSB first |
| spi_miso | output | 1 | Target-to-host data, forced to 0 when not selected |

## Verification
The assertions assume that the serial clock moves only while select is low. They also assume that each half period of the serial clock lasts several system clocks, so that a byte strobe and its following falling edge never land in the same cycle, and that select does not change in the same system cycle as a serial clock edge. The bench drives its host model on the falling system edge, and it holds every serial clock half period and every select setup and hold gap to six system cycles. It also waits three half periods between frames, so all of these conditions hold throughout the run.

// File: rtl/sram_spi_pkg.sv
package sram_spi_pkg;

    typedef enum logic [2:0] {
        ST_OPCODE,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_WR_DATA,
        ST_RD_DATA,
        ST_SR_WRITE,
        ST_SR_READ,
        ST_IGNORE
    } ctrl_state_e;

    localparam logic [7:0] CMD_LATCH_ON  = 8'h06;
    localparam logic [7:0] CMD_LATCH_OFF = 8'h04;
    localparam logic [7:0] CMD_STORE     = 8'h02;
    localparam logic [7:0] CMD_FETCH     = 8'h03;
    localparam logic [7:0] CMD_STAT_PUT  = 8'h01;
    localparam logic [7:0] CMD_STAT_GET  = 8'h05;

    localparam int STB_LATCH = 1;
    localparam int STB_PROT0 = 2;
    localparam int STB_PROT1 = 3;
    localparam int STB_MODE  = 4;
    localparam int STB_WRAP  = 5;
    localparam int STB_AUTO  = 6;

endpackage

// File: rtl/sram_spi_link.sv
module sram_spi_link #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sck_i,
    input  logic       csn_i,
    input  logic       mosi_i,
    input  logic [7:0] tx_byte_i,
    input  logic       tx_valid_i,
    output logic       sel_o,
    output logic       frame_end_o,
    output logic       byte_done_o,
    output logic [7:0] rx_byte_o,
    output logic       miso_o
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sck_pipe;
    logic [SYNC_STAGES-1:0] csn_pipe;
    logic [SYNC_STAGES-1:0] mosi_pipe;
    logic       sck_d;
    logic       csn_d;
    logic [2:0] bit_cnt;
    logic [7:0] rx_sh;
    logic [7:0] tx_sh;
    logic [7:0] tx_hold;
    logic       tx_pend;
    logic       byte_done_q;

    logic sck_s, csn_s, mosi_s, sel, rise, fall;

    assign sck_s  = sck_pipe[LAST];
    assign csn_s  = csn_pipe[LAST];
    assign mosi_s = mosi_pipe[LAST];
    assign sel    = ~csn_s;
    assign rise   = sel & sck_s & ~sck_d;
    assign fall   = sel & ~sck_s & sck_d;

    // synchronizer chain and edge history
    always_ff @(posedge clk) begin
        if (rst) begin
            sck_pipe  <= '0;
            csn_pipe  <= '1;
            mosi_pipe <= '0;
            sck_d     <= 1'b0;
            csn_d     <= 1'b1;
        end else begin
            sck_pipe[0]  <= sck_i;
            csn_pipe[0]  <= csn_i;
            mosi_pipe[0] <= mosi_i;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                sck_pipe[i]  <= sck_pipe[i-1];
                csn_pipe[i]  <= csn_pipe[i-1];
                mosi_pipe[i] <= mosi_pipe[i-1];
            end
            sck_d <= sck_s;
            csn_d <= csn_s;
        end
    end

    // byte assembly and shift-out
    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt     <= '0;
            rx_sh       <= '0;
            tx_sh       <= '0;
            tx_hold     <= '0;
            tx_pend     <= 1'b0;
            byte_done_q <= 1'b0;
        end else begin
            byte_done_q <= 1'b0;
            if (!sel) begin
                bit_cnt <= '0;
                tx_sh   <= '0;
                tx_pend <= 1'b0;
            end else begin
                if (rise) begin
                    rx_sh   <= {rx_sh[6:0], mosi_s};
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7) begin
                        byte_done_q <= 1'b1;
                    end
                end
                if (fall) begin
                    if (tx_pend) begin
                        tx_sh   <= tx_hold;
                        tx_pend <= 1'b0;
                    end else begin
                        tx_sh <= {tx_sh[6:0], 1'b0};
                    end
                end
                if (tx_valid_i) begin
                    tx_hold <= tx_byte_i;
                    tx_pend <= 1'b1;
                end
            end
        end
    end

    assign sel_o       = sel;
    assign frame_end_o = csn_s & ~csn_d;
    assign byte_done_o = byte_done_q;
    assign rx_byte_o   = rx_sh;
    assign miso_o      = tx_sh[7] & sel;

endmodule

// File: rtl/sram_spi_store.sv
module sram_spi_store #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            cells[addr_i] <= wdata_i;
        end
    end

    assign rdata_o = cells[addr_i];

endmodule

// File: rtl/sram_spi_ctrl.sv
module sram_spi_ctrl
    import sram_spi_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_i,
    input  logic              frame_end_i,
    input  logic              byte_done_i,
    input  logic [7:0]        rx_byte_i,
    input  logic [7:0]        rd_data_i,
    output logic [7:0]        tx_byte_o,
    output logic              tx_valid_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    output logic              stat_we_o,
    output logic              latch_o,
    output logic              wrap_o,
    output logic              commit_pend_o,
    output ctrl_state_e       state_o
);

    localparam int HI_W = ADDR_W - 8;

    ctrl_state_e state_q, state_d;

    logic              latch_q;
    logic [1:0]        prot_q;
    logic              mode_q;
    logic              wrap_q;
    logic              auto_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [HI_W-1:0]   addr_hi_q;
    logic              is_store_q;
    logic              commit_q;
    logic              fetch_q;
    logic              tx_valid_q;
    logic [7:0]        tx_byte_q;

    logic [7:0]        status_w;
    logic [ADDR_W-1:0] addr_full;
    logic [ADDR_W-1:0] ptr_next;

    function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                    input logic in_page);
        logic [ADDR_W-1:0] r;
        r = a + 1'b1;
        if (in_page) begin
            r = {a[ADDR_W-1:PAGE_W], r[PAGE_W-1:0]};
        end
        return r;
    endfunction

    assign status_w  = {1'b0, auto_q, wrap_q, mode_q, prot_q, latch_q, 1'b0};
    assign addr_full = {addr_hi_q, rx_byte_i};
    assign ptr_next  = step_addr(ptr_q, wrap_q);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (frame_end_i || !sel_i) begin
            state_d = ST_OPCODE;
        end else if (byte_done_i) begin
            unique case (state_q)
                ST_OPCODE: begin
                    case (rx_byte_i)
                        CMD_STORE:    state_d = latch_q ? ST_ADDR_HI : ST_IGNORE;
                        CMD_FETCH:    state_d = ST_ADDR_HI;
                        CMD_STAT_PUT: state_d = latch_q ? ST_SR_WRITE : ST_IGNORE;
                        CMD_STAT_GET: state_d = ST_SR_READ;
                        default:      state_d = ST_IGNORE;
                    endcase
                end
                ST_ADDR_HI:  state_d = ST_ADDR_LO;
                ST_ADDR_LO:  state_d = is_store_q ? ST_WR_DATA : ST_RD_DATA;
                ST_WR_DATA:  state_d = ST_WR_DATA;
                ST_RD_DATA:  state_d = ST_RD_DATA;
                ST_SR_WRITE: state_d = ST_IGNORE;
                ST_SR_READ:  state_d = ST_SR_READ;
                ST_IGNORE:   state_d = ST_IGNORE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OPCODE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs toward the array and the status byte
    always_comb begin
        mem_we_o    = byte_done_i && (state_q == ST_WR_DATA);
        stat_we_o   = byte_done_i && (state_q == ST_SR_WRITE);
        mem_addr_o  = ptr_q;
        mem_wdata_o = rx_byte_i;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q    <= 1'b0;
            prot_q     <= '0;
            mode_q     <= 1'b0;
            wrap_q     <= 1'b0;
            auto_q     <= 1'b0;
            ptr_q      <= '0;
            addr_hi_q  <= '0;
            is_store_q <= 1'b0;
            commit_q   <= 1'b0;
            fetch_q    <= 1'b0;
            tx_valid_q <= 1'b0;
            tx_byte_q  <= '0;
        end else begin
            tx_valid_q <= 1'b0;
            fetch_q    <= 1'b0;
            if (fetch_q) begin
                tx_valid_q <= 1'b1;
                tx_byte_q  <= rd_data_i;
            end
            if (frame_end_i) begin
                if (commit_q) begin
                    latch_q <= 1'b0;
                end
                commit_q <= 1'b0;
            end else if (byte_done_i) begin
                unique case (state_q)
                    ST_OPCODE: begin
                        if (rx_byte_i == CMD_LATCH_ON) begin
                            latch_q <= 1'b1;
                        end
                        if (rx_byte_i == CMD_LATCH_OFF) begin
                            latch_q <= 1'b0;
                        end
                        is_store_q <= (rx_byte_i == CMD_STORE);
                        if (rx_byte_i == CMD_STAT_GET) begin
                            tx_valid_q <= 1'b1;
                            tx_byte_q  <= status_w;
                        end
                    end
                    ST_ADDR_HI: begin
                        addr_hi_q <= rx_byte_i[HI_W-1:0];
                    end
                    ST_ADDR_LO: begin
                        ptr_q   <= addr_full;
                        fetch_q <= !is_store_q;
                    end
                    ST_WR_DATA: begin
                        ptr_q    <= ptr_next;
                        commit_q <= 1'b1;
                    end
                    ST_RD_DATA: begin
                        ptr_q   <= ptr_next;
                        fetch_q <= 1'b1;
                    end
                    ST_SR_WRITE: begin
                        prot_q   <= {rx_byte_i[STB_PROT1], rx_byte_i[STB_PROT0]};
                        mode_q   <= rx_byte_i[STB_MODE];
                        wrap_q   <= rx_byte_i[STB_WRAP];
                        auto_q   <= rx_byte_i[STB_AUTO];
                        commit_q <= 1'b1;
                    end
                    ST_SR_READ: begin
                        tx_valid_q <= 1'b1;
                        tx_byte_q  <= status_w;
                    end
                    ST_IGNORE: begin
                    end
                endcase
            end
        end
    end

    assign tx_byte_o     = tx_byte_q;
    assign tx_valid_o    = tx_valid_q;
    assign latch_o       = latch_q;
    assign wrap_o        = wrap_q;
    assign commit_pend_o = commit_q;
    assign state_o       = state_q;

endmodule

// File: rtl/sram_spi_target.sv
module sram_spi_target
    import sram_spi_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int PAGE_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic spi_sck,
    input  logic spi_csn,
    input  logic spi_mosi,
    output logic spi_miso
);

    logic              link_sel;
    logic              link_frame_end;
    logic              link_byte_done;
    logic [7:0]        link_rx_byte;
    logic [7:0]        ctrl_tx_byte;
    logic              ctrl_tx_valid;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata;
    logic [7:0]        mem_rdata;
    logic              stat_we;
    logic              latch_bit;
    logic              wrap_bit;
    logic              commit_pend;
    ctrl_state_e       ctrl_state;

    sram_spi_link #(
        .SYNC_STAGES(SYNC_STAGES)
    ) link_i (
        .clk        (clk),
        .rst        (rst),
        .sck_i      (spi_sck),
        .csn_i      (spi_csn),
        .mosi_i     (spi_mosi),
        .tx_byte_i  (ctrl_tx_byte),
        .tx_valid_i (ctrl_tx_valid),
        .sel_o      (link_sel),
        .frame_end_o(link_frame_end),
        .byte_done_o(link_byte_done),
        .rx_byte_o  (link_rx_byte),
        .miso_o     (spi_miso)
    );

    sram_spi_ctrl #(
        .ADDR_W(ADDR_W),
        .PAGE_W(PAGE_W)
    ) ctrl_i (
        .clk          (clk),
        .rst          (rst),
        .sel_i        (link_sel),
        .frame_end_i  (link_frame_end),
        .byte_done_i  (link_byte_done),
        .rx_byte_i    (link_rx_byte),
        .rd_data_i    (mem_rdata),
        .tx_byte_o    (ctrl_tx_byte),
        .tx_valid_o   (ctrl_tx_valid),
        .mem_we_o     (mem_we),
        .mem_addr_o   (mem_addr),
        .mem_wdata_o  (mem_wdata),
        .stat_we_o    (stat_we),
        .latch_o      (latch_bit),
        .wrap_o       (wrap_bit),
        .commit_pend_o(commit_pend),
        .state_o      (ctrl_state)
    );

    sram_spi_store #(
        .ADDR_W(ADDR_W)
    ) store_i (
        .clk    (clk),
        .we_i   (mem_we),
        .addr_i (mem_addr),
        .wdata_i(mem_wdata),
        .rdata_o(mem_rdata)
    );

endmodule

// File: rtl/sram_spi_target_chk.sv
module sram_spi_target_chk
    import sram_spi_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 5
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     mem_we,
    input logic                     stat_we,
    input logic                     latch_bit,
    input logic                     wrap_bit,
    input logic                     commit_pend,
    input logic                     frame_end,
    input logic [ADDR_W-PAGE_W-1:0] page_bits,
    input ctrl_state_e              state
);

    // R6
    store_needs_latch_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> latch_bit);

    // R6
    stat_needs_latch_chk: assert property (@(posedge clk) disable iff (rst)
        stat_we |-> latch_bit);

    // R7
    latch_autoclear_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_end && commit_pend) |=> !latch_bit);

    // R8
    page_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && wrap_bit) |=> (page_bits == $past(page_bits)));

    // R11
    frame_restart_chk: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (state == ST_OPCODE));

    // R3
    single_commit_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_we, stat_we}));

endmodule

bind sram_spi_target sram_spi_target_chk #(
    .ADDR_W(ADDR_W),
    .PAGE_W(PAGE_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .mem_we     (mem_we),
    .stat_we    (stat_we),
    .latch_bit  (latch_bit),
    .wrap_bit   (wrap_bit),
    .commit_pend(commit_pend),
    .frame_end  (link_frame_end),
    .page_bits  (mem_addr[ADDR_W-1:PAGE_W]),
    .state      (ctrl_state)
);

// File: tb/sram_spi_target_tb_top.sv
module sram_spi_target_tb_top;

    localparam int AW   = 11;
    localparam int MEM  = 1 << AW;
    localparam int HALF = 6;

    logic clk  = 1'b0;
    logic rst  = 1'b1;
    logic sck  = 1'b0;
    logic csn  = 1'b1;
    logic mosi = 1'b0;
    logic miso;

    int checks = 0;
    int fails  = 0;

    logic [7:0] model [MEM];
    logic       m_latch = 1'b0;
    logic [4:0] m_cfg   = 5'd0;   // status bits 6..2

    always #2 clk = ~clk;

    sram_spi_target dut_i (
        .clk     (clk),
        .rst     (rst),
        .spi_sck (sck),
        .spi_csn (csn),
        .spi_mosi(mosi),
        .spi_miso(miso)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i >= 8 - nbits; i--) begin
            mosi = tx[i];
            ticks(HALF);
            rx[i] = miso;
            sck = 1'b1;
            ticks(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic open_frame();
        csn = 1'b0;
        ticks(HALF);
    endtask

    task automatic close_frame();
        ticks(HALF);
        csn = 1'b1;
        ticks(3 * HALF);
    endtask

    function automatic logic [7:0] exp_status();
        return {1'b0, m_cfg, m_latch, 1'b0};
    endfunction

    function automatic int next_addr(input int a);
        if (m_cfg[3]) return (a & ~31) | ((a + 1) & 31);
        return (a + 1) % MEM;
    endfunction

    function automatic logic [7:0] pattern(input int seed, input int k);
        return 8'((seed * 37 + k * 11 + 5) & 255);
    endfunction

    task automatic cmd_only(input logic [7:0] op);
        logic [7:0] d;
        open_frame();
        xfer(op, 8, d);
        close_frame();
        if (op == 8'h06) m_latch = 1'b1;
        if (op == 8'h04) m_latch = 1'b0;
    endtask

    task automatic check_status(input string req);
        logic [7:0] d;
        open_frame();
        xfer(8'h05, 8, d);
        xfer(8'h00, 8, d);
        close_frame();
        chk(d == exp_status(), req, d, exp_status());
    endtask

    task automatic put_status(input logic [7:0] v);
        logic [7:0] d;
        open_frame();
        xfer(8'h01, 8, d);
        xfer(v, 8, d);
        close_frame();
        if (m_latch) begin
            m_cfg   = v[6:2];
            m_latch = 1'b0;
        end
    endtask

    task automatic store_burst(input int a16, input int n, input int seed);
        logic [7:0] d;
        int a;
        a = a16 % MEM;
        open_frame();
        xfer(8'h02, 8, d);
        xfer(8'((a16 >> 8) & 255), 8, d);
        xfer(8'(a16 & 255), 8, d);
        for (int k = 0; k < n; k++) begin
            xfer(pattern(seed, k), 8, d);
            if (m_latch) model[a] = pattern(seed, k);
            a = next_addr(a);
        end
        close_frame();
        if (m_latch && n > 0) m_latch = 1'b0;
    endtask

    task automatic fetch_check(input int a16, input int n, input string req);
        logic [7:0] d;
        int a;
        a = a16 % MEM;
        open_frame();
        xfer(8'h03, 8, d);
        xfer(8'((a16 >> 8) & 255), 8, d);
        xfer(8'(a16 & 255), 8, d);
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, 8, d);
            chk(d == model[a], req, d, model[a]);
            a = next_addr(a);
        end
        close_frame();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R11 actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int starts [5];
        int seed;
        starts = '{32'h040, 32'h047, 32'h05C, 32'h05F, 32'h07E};
        seed = 1;
        for (int i = 0; i < MEM; i++) model[i] = 8'h00;

        ticks(10);
        rst = 1'b0;
        ticks(10);

        // R11 idle output, R12 reset status
        chk(miso == 1'b0, "R11 miso idle", miso, 0);
        check_status("R12 reset status");

        // R1 latch commands
        cmd_only(8'h06);
        check_status("R1 latch on");
        cmd_only(8'h04);
        check_status("R1 latch off");

        // R2 status repeats within one frame
        cmd_only(8'h06);
        open_frame();
        xfer(8'h05, 8, d);
        for (int k = 0; k < 3; k++) begin
            xfer(8'h00, 8, d);
            chk(d == 8'h02, "R2 status repeat", d, 8'h02);
        end
        close_frame();

        // R3 status store, R7 latch clears after it
        put_status(8'h7C);
        check_status("R3 status store");
        cmd_only(8'h06);
        put_status(8'h83);
        check_status("R3 read-only bits");

        // R4 R5 R8 burst sweep in both addressing modes
        for (int mode = 0; mode < 2; mode++) begin
            cmd_only(8'h06);
            put_status(mode != 0 ? 8'h20 : 8'h00);
            check_status("R8 mode set");
            foreach (starts[s]) begin
                cmd_only(8'h06);
                store_burst(starts[s] + mode * 32'h100, 6, seed);
                seed++;
                check_status("R7 latch cleared after store");
                fetch_check(starts[s] + mode * 32'h100, 6, mode != 0 ? "R8 page wrap" : "R4 linear store");
                fetch_check(starts[s] + mode * 32'h100 + 2, 3, "R5 burst fetch");
            end
        end

        // R9 array-end wrap and ignored upper address bits
        cmd_only(8'h06);
        put_status(8'h00);
        cmd_only(8'h06);
        store_burst(32'h07FD, 5, 77);
        fetch_check(32'h07FD, 5, "R9 array wrap");
        fetch_check(32'hFFFD, 5, "R9 upper bits ignored");

        // R6 blocked store and blocked status write
        store_burst(32'h040, 4, 99);
        fetch_check(32'h040, 4, "R6 store blocked");
        put_status(8'h20);
        check_status("R6 status blocked");

        // R7 store frame with no data keeps the latch
        cmd_only(8'h06);
        open_frame();
        xfer(8'h02, 8, d);
        xfer(8'h00, 8, d);
        xfer(8'h41, 8, d);
        close_frame();
        check_status("R7 no data keeps latch");

        // R10 partial byte discarded
        open_frame();
        xfer(8'h02, 8, d);
        xfer(8'h00, 8, d);
        xfer(8'h41, 8, d);
        xfer(8'hA5, 4, d);
        close_frame();
        check_status("R10 latch kept");
        fetch_check(32'h041, 1, "R10 no partial write");

        // R11 unknown commands
        for (int op = 8'h07; op <= 8'h0F; op++) begin
            cmd_only(8'(op));
            check_status("R11 unknown command");
        end
        cmd_only(8'hFF);
        check_status("R11 unknown command");
        fetch_check(32'h047, 2, "R11 array untouched");
        chk(miso == 1'b0, "R11 miso idle", miso, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule